// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregator

This block sits in a PCIe root-port controller and turns inbound message-signalled interrupts and legacy INTx messages into one interrupt line for the host. The vectors are grouped into banks of 32. Each bank has a 64-bit capture address, a status word and a vector-enable word. An inbound memory write whose address equals an enabled bank's capture address sets the status bit that the low five bits of the write data select. Each bank feeds one sticky summary bit in a top-level status word. The four INTx lines occupy four further bits of that word.

INTx lines behave as emulated level interrupts. An assert message sets the line and its status bit. A write-1 clear of that status bit is refused until the line's deassert message has arrived. Software programs the block over a simple register bus with a write strobe and combinational read data. Inbound message writes arrive on an address/data strobe port, and INTx messages arrive as one-cycle pulses.

Top module: `msi_intx_aggregator`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: When `msi_valid` is high, bank i's capture enable (bit i of register 0x190) is set and `msi_addr` equals {word at 0xC80+4i, word at 0xC00+0x10i}, the bank sets status bit `msi_data[4:0]`. The bank's status register is at 0xC00+0x10i+4, and the bit reads as set from the next cycle.
- R3: An inbound write that matches no bank, or matches only a bank whose capture enable is clear, leaves every status register unchanged.
- R4: Writing a word to a bank status register clears the bits that are 1 in the word and leaves the rest. If a capture and a clear hit the same bit in the same cycle, the bit stays set.
- R5: Top status bit 8+i (register 0x184) becomes set one cycle after bank i holds a status bit that is also set in its vector-enable register (0xC00+0x10i+8). Captured bits whose vector enable is clear do not set it.
- R6: Top status bits 15:8 are write-1-to-clear. A clear does not take effect while the bank still holds a pending enabled vector.
- R7: An assert pulse on INTx line j sets top status bit 24+j from the next cycle. A write-1 clear of that bit is ignored until after a deassert pulse for line j has been registered. A clear that arrives in the same cycle as the deassert is also ignored.
- R8: `irq` is high exactly when some top status bit is also set in the top enable register (0x180).
- R9: The capture addresses, the vector enables, bits 7:0 of 0x190 and bits 15:8 and 27:24 of 0x180 read back as written. All other bits, and all unmapped addresses, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| msi_valid | input | 1 | Inbound message write strobe |
| msi_addr | input | MSI_AW | Inbound write address |
| msi_data | input | 32 | Inbound write data; the low bits select the vector |
| intx_assert | input | 4 | One-cycle assert messages for INTA..INTD |
| intx_deassert | input | 4 | One-cycle deassert messages for INTA..INTD |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The assertions assume that `intx_assert` and `intx_deassert` are single-cycle pulses and that inputs change only between clock edges. They also assume that a bank's status is changed only by a capture or by a status write in the same cycle. The stimulus drives every input on the falling edge and holds it for exactly one rising edge. It pulses INTx lines one at a time. It applies random message writes that either hit a programmed capture address or miss it by a corrupted low word, together with random clears and random enable changes, and checks each step against a cycle-level model in the bench.

// File: rtl/msiagg_pkg.sv
package msiagg_pkg;
   localparam int unsigned INTX_LINES   = 4;
   localparam int unsigned TOP_MSI_LSB  = 8;
   localparam int unsigned TOP_INTX_LSB = 24;
   localparam int unsigned MAX_BANKS    = 8;

   localparam int unsigned OFS_TOP_EN   = 32'h180;
   localparam int unsigned OFS_TOP_STAT = 32'h184;
   localparam int unsigned OFS_CAP_EN   = 32'h190;
   localparam int unsigned OFS_BANK     = 32'hC00;
   localparam int unsigned BANK_STRIDE  = 32'h10;
   localparam int unsigned OFS_BANK_LO  = 32'h0;
   localparam int unsigned OFS_BANK_ST  = 32'h4;
   localparam int unsigned OFS_BANK_EN  = 32'h8;
   localparam int unsigned OFS_HI       = 32'hC80;
   localparam int unsigned HI_STRIDE    = 32'h4;
endpackage

// File: rtl/msiagg_vec_bank.sv
module msiagg_vec_bank #(
   parameter int unsigned VEC    = 32,
   parameter int unsigned MSI_AW = 64,
   localparam int unsigned IDX_W = $clog2(VEC),
   localparam int unsigned HI_W  = MSI_AW - 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_stat,
   input  logic              wr_ven,
   input  logic [31:0]       wr_data,
   input  logic              sum_w1c,
   input  logic              cap_en,
   input  logic              msi_valid,
   input  logic [MSI_AW-1:0] msi_addr,
   input  logic [IDX_W-1:0]  msi_vec,
   output logic [31:0]       addr_lo,
   output logic [HI_W-1:0]   addr_hi,
   output logic [VEC-1:0]    status,
   output logic [VEC-1:0]    ven,
   output logic              summary
);
   logic [VEC-1:0] set_vec;
   logic [VEC-1:0] clr_vec;
   logic           hit;
   logic           pend;

   assign hit     = msi_valid && cap_en && (msi_addr == {addr_hi, addr_lo});
   assign set_vec = hit ? ({{(VEC-1){1'b0}}, 1'b1} << msi_vec) : '0;
   assign clr_vec = wr_stat ? wr_data[VEC-1:0] : '0;
   assign pend    = |(status & ven);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_lo <= '0;
         addr_hi <= '0;
         status  <= '0;
         ven     <= '0;
         summary <= 1'b0;
      end else begin
         if (wr_lo) addr_lo <= wr_data;
         if (wr_hi) addr_hi <= wr_data[HI_W-1:0];
         if (wr_ven) ven <= wr_data[VEC-1:0];
         status  <= (status & ~clr_vec) | set_vec;
         summary <= (summary & ~sum_w1c) | pend;
      end
   end

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && cap_en && msi_addr == {addr_hi, addr_lo}) |=> status[$past(msi_vec)]);

   p_drop_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && !cap_en && !wr_stat) |=> $stable(status));

   p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ven)) |=> summary);

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !msi_valid) |=> ((status & $past(wr_data[VEC-1:0])) == '0));
endmodule

// File: rtl/msiagg_intx_line.sv
module msiagg_intx_line (
   input  logic clk,
   input  logic rst_n,
   input  logic assert_p,
   input  logic deassert_p,
   input  logic w1c,
   output logic status,
   output logic level
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level  <= 1'b0;
         status <= 1'b0;
      end else begin
         if (assert_p)        level <= 1'b1;
         else if (deassert_p) level <= 1'b0;
         if (assert_p)             status <= 1'b1;
         else if (w1c && !level)   status <= 1'b0;
      end
   end

   p_intx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status && level) |=> status);

   p_intx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      assert_p |=> (status && level));
endmodule

// File: rtl/msi_intx_aggregator.sv
module msi_intx_aggregator
   import msiagg_pkg::*;
#(
   parameter int unsigned NUM_SETS    = 8,
   parameter int unsigned VEC_PER_SET = 32,
   parameter int unsigned REG_AW      = 12,
   parameter int unsigned MSI_AW      = 64,
   localparam int unsigned IDX_W      = $clog2(VEC_PER_SET),
   localparam int unsigned HI_W       = MSI_AW - 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              msi_valid,
   input  logic [MSI_AW-1:0] msi_addr,
   input  logic [31:0]       msi_data,
   input  logic [3:0]        intx_assert,
   input  logic [3:0]        intx_deassert,
   output logic              irq
);
   if (NUM_SETS < 1 || NUM_SETS > MAX_BANKS) begin : g_bad_sets
      $error("NUM_SETS must lie in 1..8");
   end
   if (VEC_PER_SET < 2 || VEC_PER_SET > 32 || (VEC_PER_SET & (VEC_PER_SET - 1)) != 0) begin : g_bad_vec
      $error("VEC_PER_SET must be a power of two in 2..32");
   end
   if (REG_AW < 12) begin : g_bad_aw
      $error("REG_AW must be at least 12");
   end
   if (MSI_AW < 33 || MSI_AW > 64) begin : g_bad_msi_aw
      $error("MSI_AW must lie in 33..64");
   end

   logic [NUM_SETS-1:0]   cap_en_q;
   logic [NUM_SETS-1:0]   msi_top_en_q;
   logic [INTX_LINES-1:0] intx_top_en_q;
   logic [NUM_SETS-1:0]   bank_sum;
   logic [INTX_LINES-1:0] intx_stat;
   logic [INTX_LINES-1:0] intx_lvl;
   logic [31:0]           bk_lo  [NUM_SETS];
   logic [HI_W-1:0]       bk_hi  [NUM_SETS];
   logic [VEC_PER_SET-1:0] bk_st [NUM_SETS];
   logic [VEC_PER_SET-1:0] bk_en [NUM_SETS];
   logic wr_top_en, wr_top_stat, wr_cap_en;
   logic unused_msi_bits;

   assign unused_msi_bits = ^msi_data[31:IDX_W];

   assign wr_top_en   = reg_wr && (reg_addr == REG_AW'(OFS_TOP_EN));
   assign wr_top_stat = reg_wr && (reg_addr == REG_AW'(OFS_TOP_STAT));
   assign wr_cap_en   = reg_wr && (reg_addr == REG_AW'(OFS_CAP_EN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_en_q      <= '0;
         msi_top_en_q  <= '0;
         intx_top_en_q <= '0;
      end else begin
         if (wr_cap_en) cap_en_q <= reg_wdata[NUM_SETS-1:0];
         if (wr_top_en) begin
            msi_top_en_q  <= reg_wdata[TOP_MSI_LSB +: NUM_SETS];
            intx_top_en_q <= reg_wdata[TOP_INTX_LSB +: INTX_LINES];
         end
      end
   end

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_bank
      localparam logic [REG_AW-1:0] A_BASE = REG_AW'(OFS_BANK + BANK_STRIDE * g);
      localparam logic [REG_AW-1:0] A_HI   = REG_AW'(OFS_HI + HI_STRIDE * g);
      msiagg_vec_bank #(.VEC(VEC_PER_SET), .MSI_AW(MSI_AW)) bank_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_lo     (reg_wr && reg_addr == A_BASE + REG_AW'(OFS_BANK_LO)),
         .wr_hi     (reg_wr && reg_addr == A_HI),
         .wr_stat   (reg_wr && reg_addr == A_BASE + REG_AW'(OFS_BANK_ST)),
         .wr_ven    (reg_wr && reg_addr == A_BASE + REG_AW'(OFS_BANK_EN)),
         .wr_data   (reg_wdata),
         .sum_w1c   (wr_top_stat && reg_wdata[TOP_MSI_LSB + g]),
         .cap_en    (cap_en_q[g]),
         .msi_valid (msi_valid),
         .msi_addr  (msi_addr),
         .msi_vec   (msi_data[IDX_W-1:0]),
         .addr_lo   (bk_lo[g]),
         .addr_hi   (bk_hi[g]),
         .status    (bk_st[g]),
         .ven       (bk_en[g]),
         .summary   (bank_sum[g])
      );
   end

   for (genvar j = 0; j < INTX_LINES; j++) begin : g_intx
      msiagg_intx_line line_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .assert_p   (intx_assert[j]),
         .deassert_p (intx_deassert[j]),
         .w1c        (wr_top_stat && reg_wdata[TOP_INTX_LSB + j]),
         .status     (intx_stat[j]),
         .level      (intx_lvl[j])
      );
   end

   assign irq = (|(bank_sum & msi_top_en_q)) || (|(intx_stat & intx_top_en_q));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFS_TOP_EN)) begin
         reg_rdata[TOP_MSI_LSB +: NUM_SETS]    = msi_top_en_q;
         reg_rdata[TOP_INTX_LSB +: INTX_LINES] = intx_top_en_q;
      end else if (reg_addr == REG_AW'(OFS_TOP_STAT)) begin
         reg_rdata[TOP_MSI_LSB +: NUM_SETS]    = bank_sum;
         reg_rdata[TOP_INTX_LSB +: INTX_LINES] = intx_stat;
      end else if (reg_addr == REG_AW'(OFS_CAP_EN)) begin
         reg_rdata[NUM_SETS-1:0] = cap_en_q;
      end
      for (int i = 0; i < NUM_SETS; i++) begin
         if (reg_addr == REG_AW'(OFS_BANK + BANK_STRIDE * i + OFS_BANK_LO))
            reg_rdata = bk_lo[i];
         if (reg_addr == REG_AW'(OFS_BANK + BANK_STRIDE * i + OFS_BANK_ST))
            reg_rdata = 32'(bk_st[i]);
         if (reg_addr == REG_AW'(OFS_BANK + BANK_STRIDE * i + OFS_BANK_EN))
            reg_rdata = 32'(bk_en[i]);
         if (reg_addr == REG_AW'(OFS_HI + HI_STRIDE * i))
            reg_rdata = 32'(bk_hi[i]);
      end
   end

   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_top_en_q == '0 && intx_top_en_q == '0) |-> !irq);

   p_intx_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (intx_deassert != '0 && intx_assert == '0) |=> ((intx_lvl & $past(intx_deassert)) == '0));
endmodule

// File: tb/msi_intx_aggregator_tb_top.sv
`timescale 1ns/1ps
module msi_intx_aggregator_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        msi_valid = 1'b0;
   logic [63:0] msi_addr = '0;
   logic [31:0] msi_data = '0;
   logic [3:0]  intx_assert = '0;
   logic [3:0]  intx_deassert = '0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_lo [8];
   logic [31:0] m_hi [8];
   logic [31:0] m_st [8];
   logic [31:0] m_en [8];
   logic [7:0]  m_cap, m_sum, m_ten;
   logic [3:0]  m_lvl, m_ist, m_iten;

   always #2 clk = ~clk;

   msi_intx_aggregator dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
      .msi_addr(msi_addr), .msi_data(msi_data), .intx_assert(intx_assert),
      .intx_deassert(intx_deassert), .irq(irq)
   );

   function automatic logic [31:0] exp_top_stat();
      return {4'b0, m_ist, 8'b0, m_sum, 8'b0};
   endfunction

   function automatic logic exp_irq();
      return (|(m_sum & m_ten)) || (|(m_ist & m_iten));
   endfunction

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      @(negedge clk);
      for (int i = 0; i < 8; i++) if (|(m_st[i] & m_en[i])) m_sum[i] = 1'b1;
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      if (a == 12'h180) begin m_ten = d[15:8]; m_iten = d[27:24]; end
      if (a == 12'h184) begin
         m_sum = m_sum & ~d[15:8];
         for (int j = 0; j < 4; j++) if (d[24+j] && !m_lvl[j]) m_ist[j] = 1'b0;
      end
      if (a == 12'h190) m_cap = d[7:0];
      for (int i = 0; i < 8; i++) begin
         if (a == 12'hC00 + 12'(16*i)) m_lo[i] = d;
         if (a == 12'hC04 + 12'(16*i)) m_st[i] = m_st[i] & ~d;
         if (a == 12'hC08 + 12'(16*i)) m_en[i] = d;
         if (a == 12'hC80 + 12'(4*i))  m_hi[i] = d;
      end
   endtask

   task automatic model_msi(input logic [63:0] a, input logic [31:0] d);
      for (int i = 0; i < 8; i++)
         if (m_cap[i] && a == {m_hi[i], m_lo[i]}) m_st[i][d[4:0]] = 1'b1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      model_write(a, d);
      settle();
   endtask

   task automatic msi(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      msi_valid = 1'b1; msi_addr = a; msi_data = d;
      @(negedge clk);
      msi_valid = 1'b0;
      model_msi(a, d);
      settle();
   endtask

   task automatic msi_and_clear(input int s, input logic [31:0] d, input logic [31:0] mask);
      @(negedge clk);
      msi_valid = 1'b1; msi_addr = {m_hi[s], m_lo[s]}; msi_data = d;
      reg_wr = 1'b1; reg_addr = 12'hC04 + 12'(16*s); reg_wdata = mask;
      @(negedge clk);
      msi_valid = 1'b0; reg_wr = 1'b0;
      model_write(12'hC04 + 12'(16*s), mask);
      model_msi({m_hi[s], m_lo[s]}, d);
      settle();
   endtask

   task automatic intx(input int j, input logic up);
      @(negedge clk);
      if (up) intx_assert[j] = 1'b1; else intx_deassert[j] = 1'b1;
      @(negedge clk);
      intx_assert = '0; intx_deassert = '0;
      if (up) begin m_lvl[j] = 1'b1; m_ist[j] = 1'b1; end else m_lvl[j] = 1'b0;
      settle();
   endtask

   task automatic chk_set(input string req, input int s);
      logic [31:0] v;
      rd(12'hC04 + 12'(16*s), v);
      chk(req, v, m_st[s]);
   endtask

   task automatic chk_top(input string req);
      logic [31:0] v;
      rd(12'h184, v);
      chk(req, v, exp_top_stat());
      chk({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_st[i] = '0; m_en[i] = '0; end
      m_cap = '0; m_sum = '0; m_ten = '0; m_lvl = '0; m_ist = '0; m_iten = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_top("R1 top status");
      rd(12'h180, v); chk("R1 top enable", v, 32'h0);
      rd(12'hC00, v); chk("R1 addr lo", v, 32'h0);
      chk_set("R1 set status", 5);

      // R9 readback and masking
      wr(12'h180, 32'hFFFF_FFFF);
      rd(12'h180, v); chk("R9 top enable mask", v, 32'h0F00_FF00);
      wr(12'h180, 32'h0);
      wr(12'h190, 32'hFFFF_FFFF);
      rd(12'h190, v); chk("R9 capture enable mask", v, 32'h0000_00FF);
      rd(12'h004, v); chk("R9 unmapped", v, 32'h0);
      for (int i = 0; i < 8; i++) begin
         wr(12'hC00 + 12'(16*i), 32'h4000_0000 + 32'(16*i));
         wr(12'hC80 + 12'(4*i), 32'h0000_0A00 + 32'(i));
      end
      rd(12'hC30, v); chk("R9 addr lo readback", v, 32'h4000_0030);
      rd(12'hC8C, v); chk("R9 addr hi readback", v, 32'h0000_0A03);

      // R2 capture
      msi({m_hi[3], m_lo[3]}, 32'hABCD_0025);
      chk_set("R2 capture bit 5 of set 3", 3);
      chk("R2 direct", m_st[3], 32'h0000_0020);

      // R5 no summary without vector enable
      chk_top("R5 summary needs enable");
      wr(12'hC08 + 12'(16*3), 32'h0000_0020);
      rd(12'hC38, v); chk("R9 vector enable readback", v, 32'h0000_0020);
      chk_top("R5 summary set");

      // R3 drops
      wr(12'h190, 32'h0000_00F7);
      msi({m_hi[3], m_lo[3]}, 32'h0000_0001);
      chk_set("R3 disabled set unchanged", 3);
      msi({m_hi[2], m_lo[2] ^ 32'h4}, 32'h0000_0002);
      for (int i = 0; i < 8; i++) chk_set("R3 unmatched address", i);
      wr(12'h190, 32'h0000_00FF);

      // R6 summary clear refused while pending
      wr(12'h184, 32'h0000_0800);
      chk_top("R6 clear refused while pending");
      // R4 clear then R6 clear succeeds
      wr(12'hC04 + 12'(16*3), 32'h0000_0020);
      chk_set("R4 status cleared", 3);
      wr(12'h184, 32'h0000_0800);
      chk_top("R6 summary cleared");

      // R4 simultaneous capture and clear
      msi({m_hi[1], m_lo[1]}, 32'h0000_0007);
      msi_and_clear(1, 32'h0000_0007, 32'h0000_0080);
      chk_set("R4 set wins over clear", 1);
      msi_and_clear(1, 32'h0000_0002, 32'h0000_0080);
      chk_set("R4 other bit cleared", 1);

      // R7 INTx level behaviour
      intx(2, 1'b1);
      chk_top("R7 assert sets bit 26");
      wr(12'h184, 32'h0400_0000);
      chk_top("R7 clear ignored while asserted");
      intx(2, 1'b0);
      chk_top("R7 status stays after deassert");
      wr(12'h184, 32'h0400_0000);
      chk_top("R7 clear after deassert");

      // R8 irq gating
      intx(0, 1'b1);
      chk_top("R8 irq masked");
      wr(12'h180, 32'h0100_0000);
      chk_top("R8 irq from INTA");
      wr(12'h180, 32'h0000_0000);
      chk_top("R8 irq off");
      intx(0, 1'b0);
      wr(12'h184, 32'h0100_0000);

      // random phase
      for (int i = 0; i < 8; i++) wr(12'hC08 + 12'(16*i), $urandom());
      for (int n = 0; n < 400; n++) begin
         int op, s;
         op = int'($urandom_range(0, 9));
         s  = int'($urandom_range(0, 7));
         if (op < 5) begin
            if (op == 4) msi({m_hi[s], m_lo[s] ^ 32'h10}, $urandom());
            else msi({m_hi[s], m_lo[s]}, $urandom());
         end else if (op == 5) wr(12'hC04 + 12'(16*s), $urandom());
         else if (op == 6) wr(12'h184, $urandom());
         else if (op == 7) wr(12'hC08 + 12'(16*s), $urandom());
         else if (op == 8) wr(12'h180, $urandom());
         else wr(12'h190, {24'b0, 8'($urandom()) | 8'h0F});
         chk_set("R2 R3 R4 random set status", s);
         chk_top("R5 R6 R8 random top status");
      end
      report();
   end
endmodule